// File: doc/BRIEF.md
# Legacy Divisor Port Fallback Controller

This block is the register-access side of a two-mode UART. In the default mode the UART behaves like a 16550. In the second mode, the extended mode, additional control registers take effect. A simple host bus with an address, write data, read data and read and write strobes reaches the block's registers. Two offsets are shared. Depending on a bank selection held in the line register, they lead either to the serial data ports or to one of two pairs of divisor byte ports.

The legacy divisor pair exists so that 16550-era software keeps working. Any read or write through it pulls the UART back into the 16550 mode. The same access clears a set of control bits, and which bits depends on the mode and on a lock bit. The alternate divisor pair sets the same divisor with no side effect, and extended-mode software is expected to use it. Each divisor byte write sends a single-cycle load pulse to the baud generator. The serial data path is outside this block. It sees only the transmit-write and receive-read strobes.

Top module: `legacy_divisor_fallback`

## Requirements
- R1: Synchronous active-high reset clears the line, ext1, ext2 and modem registers to 0, so the block starts in 16550 mode. The divisor value after reset is undefined, and div_load is 0 after reset.
- R2: Banks are chosen by the line register at offset 3, which is reachable in every bank. Bit 7 = 0 selects the normal bank. Bit 7 = 1 with bits 6:5 = 00 selects the legacy bank, and bits 6:5 = 01 selects the alternate bank. In the normal bank, offset 0 is the data port. A write there raises tx_wr in the same cycle, and a read alone raises rx_rd and returns 0. Neither changes the divisor or the control registers.
- R3: In the legacy bank, offset 0 writes the divisor low byte and offset 1 writes the high byte (unless R7 applies). The new byte appears on divisor in the cycle after the write, and div_load is high for exactly that one cycle.
- R4: In the alternate bank, offsets 0 and 1 write the divisor low and high bytes with the load pulse of R3. They never change the mode or any control register.
- R5: A legacy divisor access (read or write) in extended mode (ext1 bit 0 = 1) clears ext1 bits 0, 5 and 7, ext2 bits 0 to 5 and modem bits 2 to 7, all in one cycle. This returns the block to 16550 mode.
- R6: A legacy divisor access in 16550 mode with the lock bit (ext2 bit 7) at 0 clears ext1 bits 5 and 7 and ext2 bits 0 to 5. It leaves the modem register unchanged.
- R7: A legacy divisor access in 16550 mode with the lock bit at 1 changes nothing. The divisor keeps its value, no load pulse is issued and no control bit is cleared.
- R8: A read of a legacy divisor port triggers the same fallback as a write.
- R9: In the legacy bank, offsets 2 and 4 to 7 read as 0 and ignore writes. So do every offset except 3 in a bank selection with bits 6:5 = 10 or 11.
- R10: Reads of either divisor pair return the stored low byte at offset 0 and the high byte at offset 1.
- R11: In the alternate bank, offset 2 is ext1 and offset 4 is ext2. In the normal bank, offset 4 is the modem register. Each of these reads back what was written. ext_mode always equals ext1 bit 0.
- R12: When write and read are both asserted in one cycle, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| divisor | output | 16 | Baud divisor |
| div_load | output | 1 | One-cycle pulse after any divisor byte write |
| ext_mode | output | 1 | 1 = extended mode, 0 = 16550 mode |
| tx_wr | output | 1 | Data-port write strobe |
| rx_rd | output | 1 | Data-port read strobe |
| ctl_line | output | 8 | Line register (bank selection in bits 7:5) |
| ctl_ext1 | output | 8 | Extended control 1 (bit 0 = mode) |
| ctl_ext2 | output | 8 | Extended control 2 (bit 7 = lock) |
| ctl_modem | output | 8 | Modem control register |

## Verification
Some rules are checked by the embedded properties on every cycle. A legacy write updates the low byte and raises the load pulse in the next cycle. A legacy access in extended mode leaves the mode cleared with its listed bits at zero. A locked access in 16550 mode leaves every register and the divisor untouched. An alternate write never moves a control register. Reserved reads return zero. Other behaviour only the bench scenarios can show. These are the exact clear masks across mode and lock combinations and read-triggered fallback. They also include the isolation of the data port from the divisor, readback through both pairs, and the effect of mixed bank selections reached through random sequences.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int ADDR_W = 3;
    localparam int REG_W  = 8;
    localparam int DIV_W  = 16;

    // Offsets that the address decoder depends on
    localparam int OFS_LO   = 0;
    localparam int OFS_HI   = 1;
    localparam int OFS_EXT1 = 2;
    localparam int OFS_LINE = 3;
    localparam int OFS_AUX  = 4;

    // Bit positions that other logic decodes
    localparam int MODE_BIT    = 0;   // ext1: extended mode
    localparam int LOCK_BIT    = 7;   // ext2: lock
    localparam int BANK_EN_BIT = 7;   // line: bank enable

    typedef enum logic [1:0] {
        BANK_NORM,
        BANK_LEG,
        BANK_ALT,
        BANK_VOID
    } bank_e;

    typedef enum logic [3:0] {
        ACC_RSVD,
        ACC_DATA,
        ACC_LEG_LO,
        ACC_LEG_HI,
        ACC_ALT_LO,
        ACC_ALT_HI,
        ACC_LINE,
        ACC_EXT1,
        ACC_EXT2,
        ACC_MODEM
    } acc_e;

    typedef struct packed {
        logic [REG_W-1:0] ext1;
        logic [REG_W-1:0] ext2;
        logic [REG_W-1:0] modem;
    } clr_mask_t;

    // Clear masks, indexed by mode and lock state
    localparam clr_mask_t MASK_FROM_EXT  = '{ext1: 8'hA1, ext2: 8'h3F, modem: 8'hFC};
    localparam clr_mask_t MASK_NX_OPEN   = '{ext1: 8'hA0, ext2: 8'h3F, modem: 8'h00};
    localparam clr_mask_t MASK_NONE      = '{ext1: 8'h00, ext2: 8'h00, modem: 8'h00};

    function automatic clr_mask_t fallback_mask(input logic ext, input logic lock);
        if (ext)
            return MASK_FROM_EXT;
        else if (!lock)
            return MASK_NX_OPEN;
        else
            return MASK_NONE;
    endfunction

    function automatic bank_e bank_of(input logic [REG_W-1:0] line);
        if (!line[BANK_EN_BIT])
            return BANK_NORM;
        case (line[6:5])
            2'b00:   return BANK_LEG;
            2'b01:   return BANK_ALT;
            default: return BANK_VOID;
        endcase
    endfunction

    function automatic logic is_legacy(input acc_e a);
        return (a == ACC_LEG_LO) || (a == ACC_LEG_HI);
    endfunction

endpackage

// File: rtl/lfb_decode.sv
module lfb_decode
    import lfb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = REG_W
) (
    input  logic [AW-1:0] addr,
    input  logic [RW-1:0] line,
    output acc_e          acc
);

    bank_e bank;

    always_comb begin
        bank = bank_of(line);
        acc  = ACC_RSVD;
        if (addr == AW'(OFS_LINE)) begin
            acc = ACC_LINE;
        end else begin
            case (bank)
                BANK_NORM: begin
                    if (addr == AW'(OFS_LO))       acc = ACC_DATA;
                    else if (addr == AW'(OFS_AUX)) acc = ACC_MODEM;
                end
                BANK_LEG: begin
                    if (addr == AW'(OFS_LO))       acc = ACC_LEG_LO;
                    else if (addr == AW'(OFS_HI))  acc = ACC_LEG_HI;
                end
                BANK_ALT: begin
                    if (addr == AW'(OFS_LO))        acc = ACC_ALT_LO;
                    else if (addr == AW'(OFS_HI))   acc = ACC_ALT_HI;
                    else if (addr == AW'(OFS_EXT1)) acc = ACC_EXT1;
                    else if (addr == AW'(OFS_AUX))  acc = ACC_EXT2;
                end
                default: acc = ACC_RSVD;
            endcase
        end
    end

endmodule

// File: rtl/lfb_fallback.sv
module lfb_fallback
    import lfb_pkg::*;
(
    input  acc_e      acc,
    input  logic      acc_valid,
    input  logic      ext_mode,
    input  logic      lock,
    output logic      fb_fire,
    output logic      leg_block,
    output clr_mask_t mask
);

    logic leg_hit;

    always_comb begin
        leg_hit   = acc_valid && is_legacy(acc);
        leg_block = leg_hit && !ext_mode && lock;
        fb_fire   = leg_hit && !leg_block;
        mask      = fb_fire ? fallback_mask(ext_mode, lock) : MASK_NONE;
    end

endmodule

// File: rtl/lfb_divisor.sv
module lfb_divisor #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW/BW-1:0] lane_wr,
    input  logic [BW-1:0] wdata,
    output logic [DW-1:0] div,
    output logic          load
);

    localparam int NB = DW / BW;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [BW-1:0] q;
        // Contents undefined until written: no reset on purpose
        always_ff @(posedge clk) begin
            if (lane_wr[i])
                q <= wdata;
        end
        assign div[i*BW +: BW] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            load <= 1'b0;
        else
            load <= |lane_wr;
    end

    // R3
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        !(|lane_wr) |=> !load);

endmodule

// File: rtl/legacy_divisor_fallback.sv
module legacy_divisor_fallback
    import lfb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = REG_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [RW-1:0] bus_wdata,
    output logic [RW-1:0] bus_rdata,
    output logic [DW-1:0] divisor,
    output logic          div_load,
    output logic          ext_mode,
    output logic          tx_wr,
    output logic          rx_rd,
    output logic [RW-1:0] ctl_line,
    output logic [RW-1:0] ctl_ext1,
    output logic [RW-1:0] ctl_ext2,
    output logic [RW-1:0] ctl_modem
);

    localparam int NB = DW / RW;

    acc_e      acc;
    logic      acc_valid;
    logic      rd_only;
    logic      fb_fire;
    logic      leg_block;
    clr_mask_t mask;
    logic      lo_wr;
    logic      hi_wr;
    logic [NB-1:0] lane_wr;

    lfb_decode #(.AW(AW), .RW(RW)) u_dec (
        .addr (bus_addr),
        .line (ctl_line),
        .acc  (acc)
    );

    assign acc_valid = bus_wr || bus_rd;
    assign rd_only   = bus_rd && !bus_wr;

    lfb_fallback u_fb (
        .acc       (acc),
        .acc_valid (acc_valid),
        .ext_mode  (ext_mode),
        .lock      (ctl_ext2[LOCK_BIT]),
        .fb_fire   (fb_fire),
        .leg_block (leg_block),
        .mask      (mask)
    );

    always_comb begin
        lo_wr   = bus_wr && (((acc == ACC_LEG_LO) && !leg_block) || (acc == ACC_ALT_LO));
        hi_wr   = bus_wr && (((acc == ACC_LEG_HI) && !leg_block) || (acc == ACC_ALT_HI));
        lane_wr    = '0;
        lane_wr[0] = lo_wr;
        lane_wr[1] = hi_wr;
    end

    lfb_divisor #(.DW(DW), .BW(RW)) u_div (
        .clk     (clk),
        .rst     (rst),
        .lane_wr (lane_wr),
        .wdata   (bus_wdata),
        .div     (divisor),
        .load    (div_load)
    );

    // Control registers: host writes, else fallback clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_line  <= '0;
            ctl_ext1  <= '0;
            ctl_ext2  <= '0;
            ctl_modem <= '0;
        end else begin
            if (bus_wr && acc == ACC_LINE)
                ctl_line <= bus_wdata;
            if (bus_wr && acc == ACC_EXT1)
                ctl_ext1 <= bus_wdata;
            else
                ctl_ext1 <= ctl_ext1 & ~mask.ext1;
            if (bus_wr && acc == ACC_EXT2)
                ctl_ext2 <= bus_wdata;
            else
                ctl_ext2 <= ctl_ext2 & ~mask.ext2;
            if (bus_wr && acc == ACC_MODEM)
                ctl_modem <= bus_wdata;
            else
                ctl_modem <= ctl_modem & ~mask.modem;
        end
    end

    assign ext_mode = ctl_ext1[MODE_BIT];
    assign tx_wr    = bus_wr && (acc == ACC_DATA);
    assign rx_rd    = rd_only && (acc == ACC_DATA);

    always_comb begin
        case (acc)
            ACC_LEG_LO, ACC_ALT_LO: bus_rdata = divisor[RW-1:0];
            ACC_LEG_HI, ACC_ALT_HI: bus_rdata = divisor[2*RW-1:RW];
            ACC_LINE:               bus_rdata = ctl_line;
            ACC_EXT1:               bus_rdata = ctl_ext1;
            ACC_EXT2:               bus_rdata = ctl_ext2;
            ACC_MODEM:              bus_rdata = ctl_modem;
            default:                bus_rdata = '0;
        endcase
    end

    // R3
    leg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && acc == ACC_LEG_LO && !leg_block)
        |=> (div_load && divisor[RW-1:0] == $past(bus_wdata)));

    // R4
    alt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (acc == ACC_ALT_LO || acc == ACC_ALT_HI))
        |=> ($stable(ctl_ext1) && $stable(ctl_ext2) && $stable(ctl_modem)));

    // R5
    ext_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && is_legacy(acc) && ext_mode)
        |=> (!ext_mode && !ctl_ext1[7] && !ctl_ext1[5] && ctl_modem[7:2] == '0));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && is_legacy(acc) && !ext_mode && ctl_ext2[LOCK_BIT])
        |=> (!div_load && $stable(divisor) && $stable(ctl_ext1)
             && $stable(ctl_ext2) && $stable(ctl_modem)));

    // R2
    data_iso_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && acc == ACC_DATA) |=> !div_load);

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_only && acc == ACC_RSVD) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_legacy_divisor_fallback.sv
module sim_legacy_divisor_fallback;

    localparam int K_RSV = 0, K_DATA = 1, K_LLO = 2, K_LHI = 3, K_ALO = 4,
                   K_AHI = 5, K_LINE = 6, K_E1 = 7, K_E2 = 8, K_MOD = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] divisor;
    logic        div_load, ext_mode, tx_wr, rx_rd;
    logic [7:0]  ctl_line, ctl_ext1, ctl_ext2, ctl_modem;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  m_line, m_e1, m_e2, m_mod;
    logic [15:0] m_div;
    logic [1:0]  m_known;
    logic        m_load;

    always #10 clk = ~clk;

    legacy_divisor_fallback u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .divisor(divisor),
        .div_load(div_load), .ext_mode(ext_mode), .tx_wr(tx_wr), .rx_rd(rx_rd),
        .ctl_line(ctl_line), .ctl_ext1(ctl_ext1), .ctl_ext2(ctl_ext2), .ctl_modem(ctl_modem)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int tb_kind(input logic [2:0] a, input logic [7:0] line);
        if (a == 3'd3) return K_LINE;
        if (!line[7]) begin
            if (a == 3'd0) return K_DATA;
            if (a == 3'd4) return K_MOD;
            return K_RSV;
        end
        if (line[6:5] == 2'b00) begin
            if (a == 3'd0) return K_LLO;
            if (a == 3'd1) return K_LHI;
            return K_RSV;
        end
        if (line[6:5] == 2'b01) begin
            if (a == 3'd0) return K_ALO;
            if (a == 3'd1) return K_AHI;
            if (a == 3'd2) return K_E1;
            if (a == 3'd4) return K_E2;
        end
        return K_RSV;
    endfunction

    task automatic compare_state(input string req);
        chk(ctl_line == m_line,  {req, " line"},  ctl_line,  m_line);
        chk(ctl_ext1 == m_e1,    {req, " ext1"},  ctl_ext1,  m_e1);
        chk(ctl_ext2 == m_e2,    {req, " ext2"},  ctl_ext2,  m_e2);
        chk(ctl_modem == m_mod,  {req, " modem"}, ctl_modem, m_mod);
        chk(ext_mode == m_e1[0], {req, " R11 ext_mode"}, ext_mode, m_e1[0]);
        chk(div_load == m_load,  {req, " div_load"}, div_load, m_load);
        if (m_known[0]) chk(divisor[7:0] == m_div[7:0], {req, " div lo"}, divisor[7:0], m_div[7:0]);
        if (m_known[1]) chk(divisor[15:8] == m_div[15:8], {req, " div hi"}, divisor[15:8], m_div[15:8]);
    endtask

    // One bus access: driven just after a falling edge, results sampled at the next one
    task automatic bus_op(input bit wr, input bit rd, input logic [2:0] a,
                          input logic [7:0] d, input string req);
        int   k;
        bit   leg, blk;
        logic [7:0] exp_rd;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        k = tb_kind(a, m_line);
        chk(tx_wr == (wr && k == K_DATA), {req, " R2 tx_wr"}, tx_wr, wr && k == K_DATA);
        chk(rx_rd == (rd && !wr && k == K_DATA), {req, " R2 R12 rx_rd"}, rx_rd, rd && !wr && k == K_DATA);
        if (rd && !wr) begin
            exp_rd = 8'h00;
            case (k)
                K_LLO, K_ALO: exp_rd = m_div[7:0];
                K_LHI, K_AHI: exp_rd = m_div[15:8];
                K_LINE: exp_rd = m_line;
                K_E1:   exp_rd = m_e1;
                K_E2:   exp_rd = m_e2;
                K_MOD:  exp_rd = m_mod;
                default: exp_rd = 8'h00;
            endcase
            if (!((k == K_LLO || k == K_ALO) && !m_known[0]) &&
                !((k == K_LHI || k == K_AHI) && !m_known[1]))
                chk(bus_rdata == exp_rd, {req, " R10 R9 rdata"}, bus_rdata, exp_rd);
        end
        // model update
        m_load = 1'b0;
        leg = (wr || rd) && (k == K_LLO || k == K_LHI);
        blk = leg && !m_e1[0] && m_e2[7];
        if (leg && !blk) begin
            if (m_e1[0]) begin
                m_e1 &= ~8'hA1; m_e2 &= ~8'h3F; m_mod &= ~8'hFC;
            end else begin
                m_e1 &= ~8'hA0; m_e2 &= ~8'h3F;
            end
        end
        if (wr) begin
            case (k)
                K_LLO: if (!blk) begin m_div[7:0] = d; m_known[0] = 1'b1; m_load = 1'b1; end
                K_LHI: if (!blk) begin m_div[15:8] = d; m_known[1] = 1'b1; m_load = 1'b1; end
                K_ALO: begin m_div[7:0] = d; m_known[0] = 1'b1; m_load = 1'b1; end
                K_AHI: begin m_div[15:8] = d; m_known[1] = 1'b1; m_load = 1'b1; end
                K_LINE: m_line = d;
                K_E1:   m_e1 = d;
                K_E2:   m_e2 = d;
                K_MOD:  m_mod = d;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        compare_state(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_line = 0; m_e1 = 0; m_e2 = 0; m_mod = 0; m_div = 0; m_known = 0; m_load = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        compare_state("R1");

        // R3 legacy writes, R10 readback, R8 reads in 16550 mode with lock 0
        bus_op(1, 0, 3'd3, 8'h80, "R2 line");
        bus_op(1, 0, 3'd0, 8'h34, "R3 lo");
        bus_op(1, 0, 3'd1, 8'h12, "R3 hi");
        bus_op(0, 1, 3'd0, 8'h00, "R10 R8 lo");
        bus_op(0, 1, 3'd1, 8'h00, "R10 R8 hi");
        // R2 data port leaves divisor alone
        bus_op(1, 0, 3'd3, 8'h00, "R2 line");
        bus_op(1, 0, 3'd0, 8'hAA, "R2 tx");
        bus_op(0, 1, 3'd0, 8'h00, "R2 rx");
        bus_op(1, 1, 3'd0, 8'h5A, "R12 both");
        bus_op(1, 0, 3'd4, 8'hFF, "R11 modem");
        // R4 alternate pair in extended mode
        bus_op(1, 0, 3'd3, 8'hA0, "R4 line");
        bus_op(1, 0, 3'd2, 8'hFF, "R11 ext1");
        bus_op(1, 0, 3'd4, 8'h3F, "R11 ext2");
        bus_op(1, 0, 3'd0, 8'h78, "R4 alo");
        bus_op(1, 0, 3'd1, 8'h56, "R4 ahi");
        bus_op(0, 1, 3'd0, 8'h00, "R10 alo");
        // R5 legacy write in extended mode
        bus_op(1, 0, 3'd3, 8'h80, "R5 line");
        bus_op(1, 0, 3'd1, 8'h9A, "R5 fallback");
        chk(ctl_ext1 == 8'h5E, "R5 ext1 value", ctl_ext1, 8'h5E);
        chk(ctl_modem == 8'h03, "R5 modem value", ctl_modem, 8'h03);
        // R6 and R8: legacy read in 16550 mode, lock 0
        bus_op(1, 0, 3'd3, 8'h00, "R6 line");
        bus_op(1, 0, 3'd4, 8'hFF, "R6 modem");
        bus_op(1, 0, 3'd3, 8'hA0, "R6 line");
        bus_op(1, 0, 3'd2, 8'hFE, "R6 ext1");
        bus_op(1, 0, 3'd4, 8'h3F, "R6 ext2");
        bus_op(1, 0, 3'd3, 8'h80, "R6 line");
        bus_op(0, 1, 3'd0, 8'h00, "R8 R6 read fallback");
        chk(ctl_ext1 == 8'h5E && ctl_modem == 8'hFF, "R6 ext1/modem", {ctl_ext1, ctl_modem}, 16'h5EFF);
        // R7 lock held
        bus_op(1, 0, 3'd3, 8'hA0, "R7 line");
        bus_op(1, 0, 3'd2, 8'hFE, "R7 ext1");
        bus_op(1, 0, 3'd4, 8'hBF, "R7 ext2");
        bus_op(1, 0, 3'd3, 8'h80, "R7 line");
        bus_op(1, 0, 3'd0, 8'h11, "R7 locked write");
        chk(divisor[7:0] == 8'h78, "R7 divisor kept", divisor[7:0], 8'h78);
        bus_op(0, 1, 3'd1, 8'h00, "R7 locked read");
        // R9 reserved offsets
        for (int a = 2; a < 8; a++) begin
            if (a == 3) continue;
            bus_op(1, 0, 3'(a), 8'hC3, "R9 rsvd write");
            bus_op(0, 1, 3'(a), 8'h00, "R9 rsvd read");
        end
        bus_op(1, 0, 3'd3, 8'hC0, "R9 void bank");
        bus_op(1, 0, 3'd0, 8'h77, "R9 void write");
        bus_op(0, 1, 3'd1, 8'h00, "R9 void read");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [7:0] d;
            logic [2:0] a;
            bit wr, rd;
            sel = $urandom_range(0, 9);
            d = 8'($urandom);
            a = 3'($urandom_range(0, 7));
            wr = $urandom_range(0, 1) == 1;
            rd = !wr || ($urandom_range(0, 7) == 0);
            if (sel < 2) begin
                case ($urandom_range(0, 3))
                    0: d = 8'h00;
                    1: d = 8'h80 | (d & 8'h1F);
                    2: d = 8'hA0 | (d & 8'h1F);
                    default: ;
                endcase
                bus_op(1, 0, 3'd3, d, "R2 R11 rand line");
            end else begin
                bus_op(wr, rd, a, d, "R3 R4 R5 R6 R7 rand");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule